// File: doc/BRIEF.md
# Energy Detect Debounce Filter

This block turns a noisy, asynchronous energy-present indication from a line front end into a clean, debounced level. The raw input is first resynchronised. A four-state machine then tracks it: quiet, qualifying, active and dropping out. Each move out of a waiting state needs the raw level to hold steady for a programmed interval.

Three 8-bit interval fields set the waits:
- a short one, for energy to qualify;
- a long one, for a qualification to be abandoned;
- a longer one, for an active link to be declared gone.

A chain of two prescalers scales each field from the clock. Qualification counts in units of 2^SHORT_PRE_LOG2 cycles. Both absence intervals count in units of 2^(SHORT_PRE_LOG2+LONG_PRE_LOG2) cycles. A test bit removes both prescalers so that every field counts single clock cycles.

All fields sit in one 32-bit configuration word that is written through a simple write strobe and read back combinationally. Only the hard reset restores their defaults.

Top module: `energy_debounce`

## Requirements
- R1: After reset the configuration word reads 0x00102040, energyOut is low, and the machine is in the quiet state. The word holds the test bit at bit 31 (0), the qualify field at bits 23:16 (0x10), the abandon field at bits 15:8 (0x20) and the drop-out field at bits 7:0 (0x40).
- R2: A cycle with regWrEn high loads the word at the clock edge, using the field positions given in R1. Bits 30:24 are discarded and always read as zero. regRdData shows the new value from the next cycle on.
- R3: energyRaw passes through a two-flop synchronizer. While the machine is quiet and the synchronized level is low, it stays quiet and energyOut stays low.
- R4: The first edge that samples energyRaw high counts as edge 1, and the input then stays high. energyOut rises at edge 4 + Q·S, where Q is the qualify field and S = 2^SHORT_PRE_LOG2 (S = 1 with the test bit set). It stays low before that edge.
- R5: If energy goes away during qualification and stays away for the abandon interval, the machine returns to quiet and energyOut never rises.
- R6: energyOut is high and energyRaw then goes low and stays low. Counting the first edge that samples it low as edge 1, energyOut falls at edge 4 + D·L, where D is the drop-out field and L = 2^(SHORT_PRE_LOG2+LONG_PRE_LOG2) (L = 1 with the test bit set). It falls only from the dropping-out state.
- R7: Energy that returns while the machine is dropping out sends it straight back to active. energyOut stays high, and the drop-out count starts over, so a later loss again takes the full 4 + D·L edges.
- R8: Every change of the synchronized level during qualification restarts the count. After a bounce, the rise time of R4 is measured from the last rising edge of energyRaw.
- R9: A field value of zero makes its transition fire in the first cycle in which its condition holds after the state is entered. With the test bit set, this gives a rise at edge 4 and a fall at edge 4.
- R10: With the test bit set (bit 31 = 1), the fields count clock cycles directly. With it clear, the prescalers apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (reference clock of the timers) |
| rstN | input | 1 | Asynchronous active-low hard reset |
| regWrEn | input | 1 | Write strobe for the configuration word |
| regWrData | input | 32 | Configuration word to write |
| regRdData | output | 32 | Current configuration word |
| energyRaw | input | 1 | Raw asynchronous energy-present indication |
| energyOut | output | 1 | Debounced energy indication |

## Verification
Every timed result has a known due edge. A change on energyRaw needs two edges to cross the synchronizer and one more for the machine to enter its waiting state. The waiting state then holds for field·scale + 1 further edges, so energyOut rises or falls exactly at edge 4 + field·scale. A register write is visible on regRdData one edge after the strobe.

Inputs are driven on the falling clock edge and outputs are sampled on a later falling edge. Each timed case is checked on both sides of its due edge: the output must still hold its old value one edge early and must show the new value exactly at the due edge. The bench is built with both prescalers shrunk to 2 bits, so the scaled cases, including the reset defaults, finish within the run.

// File: rtl/edb_pkg.sv
package edb_pkg;
  localparam int CFG_W      = 32;
  localparam int TMR_W      = 8;
  localparam int FAST_BIT   = 31;
  localparam int QUAL_LSB   = 16;
  localparam int ABORT_LSB  = 8;
  localparam int DROP_LSB   = 0;
  localparam logic [CFG_W-1:0] CFG_MASK  = 32'h80FF_FFFF;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0010_2040;

  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_PEND_ON  = 2'd1,
    ST_ON       = 2'd2,
    ST_PEND_OFF = 2'd3
  } edbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic useLongTick;
  } edbCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic energy;
    logic levelChange;
    logic qualDone;
    logic abortDone;
    logic dropDone;
  } edbStat_t;
endpackage

// File: rtl/edb_datapath.sv
module edb_datapath
  import edb_pkg::*;
#(
  parameter int SHORT_PRE_LOG2 = 11,
  parameter int LONG_PRE_LOG2  = 9,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  output logic [CFG_W-1:0] regRdData,
  input  logic             energyRaw,
  input  edbCtrl_t         ctrl,
  output edbStat_t         stat
);
  logic [CFG_W-1:0] cfgQ;
  logic             fastMode;
  logic [TMR_W-1:0] qualLim, abortLim, dropLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= CFG_RESET;
    else if (regWrEn) cfgQ <= regWrData & CFG_MASK;
  end

  assign regRdData = cfgQ;
  assign fastMode  = cfgQ[FAST_BIT];
  assign qualLim   = cfgQ[QUAL_LSB +: TMR_W];
  assign abortLim  = cfgQ[ABORT_LSB +: TMR_W];
  assign dropLim   = cfgQ[DROP_LSB +: TMR_W];

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   energySync, energyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ      <= '0;
      energyPrev <= 1'b0;
    end else begin
      syncQ      <= {syncQ[SYNC_STAGES-2:0], energyRaw};
      energyPrev <= energySync;
    end
  end
  assign energySync = syncQ[SYNC_STAGES-1];

  // cascaded prescalers
  logic [SHORT_PRE_LOG2-1:0] preShort;
  logic [LONG_PRE_LOG2-1:0]  preLong;
  logic                      shortTick, longTick, unitTick;

  assign shortTick = &preShort;
  assign longTick  = shortTick & (&preLong);
  assign unitTick  = fastMode | (ctrl.useLongTick ? longTick : shortTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preShort <= '0;
      preLong  <= '0;
    end else if (ctrl.clrCnt) begin
      preShort <= '0;
      preLong  <= '0;
    end else begin
      preShort <= preShort + 1'b1;
      if (shortTick) preLong <= preLong + 1'b1;
    end
  end

  // interval counter, saturating
  logic [TMR_W-1:0] intervalCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                intervalCnt <= '0;
    else if (ctrl.clrCnt)                     intervalCnt <= '0;
    else if (unitTick && (intervalCnt != '1)) intervalCnt <= intervalCnt + 1'b1;
  end

  assign stat.energy      = energySync;
  assign stat.levelChange = energySync ^ energyPrev;
  assign stat.qualDone    = intervalCnt >= qualLim;
  assign stat.abortDone   = intervalCnt >= abortLim;
  assign stat.dropDone    = intervalCnt >= dropLim;
endmodule

// File: rtl/edb_ctrl.sv
module edb_ctrl
  import edb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  edbStat_t  stat,
  output edbCtrl_t  ctrl,
  output edbState_t curState,
  output logic      energyOut
);
  edbState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_OFF:      if (stat.energy) nextState = ST_PEND_ON;
      ST_PEND_ON: begin
        if (!stat.levelChange) begin
          if (stat.energy && stat.qualDone)        nextState = ST_ON;
          else if (!stat.energy && stat.abortDone) nextState = ST_OFF;
        end
      end
      ST_ON:       if (!stat.energy) nextState = ST_PEND_OFF;
      ST_PEND_OFF: begin
        if (stat.energy)        nextState = ST_ON;
        else if (stat.dropDone) nextState = ST_OFF;
      end
      default:     nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nextState;
  end

  assign ctrl.clrCnt      = (nextState != curState) | stat.levelChange;
  assign ctrl.useLongTick = ~stat.energy;
  assign energyOut        = (curState == ST_ON) || (curState == ST_PEND_OFF);
endmodule

// File: rtl/energy_debounce.sv
module energy_debounce
  import edb_pkg::*;
#(
  parameter int SHORT_PRE_LOG2 = 11,
  parameter int LONG_PRE_LOG2  = 9,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        energyRaw,
  output logic        energyOut
);
  edbCtrl_t  ctrl;
  edbStat_t  stat;
  edbState_t curState;
  logic      energySync;

  edb_datapath #(
    .SHORT_PRE_LOG2(SHORT_PRE_LOG2),
    .LONG_PRE_LOG2 (LONG_PRE_LOG2),
    .SYNC_STAGES   (SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .energyRaw (energyRaw),
    .ctrl      (ctrl),
    .stat      (stat)
  );

  edb_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .ctrl      (ctrl),
    .curState  (curState),
    .energyOut (energyOut)
  );

  assign energySync = stat.energy;
endmodule

// File: rtl/edb_checker.sv
module edb_checker
  import edb_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        energySync,
  input edbState_t   state,
  input logic        energyOut,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData
);
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == {$past(regWrData[31]), 7'b0, $past(regWrData[23:0])}); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !energySync) |=> (state == ST_OFF && !energyOut)); // R3

  AST_RISE_FROM_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(energyOut) |-> ($past(state) == ST_PEND_ON && state == ST_ON)); // R4

  AST_FALL_FROM_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(energyOut) |-> ($past(state) == ST_PEND_OFF && state == ST_OFF)); // R6

  AST_RETURN_TO_ON: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND_OFF && energySync) |=> (state == ST_ON)); // R7

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && energySync) |=> (state == ST_ON)); // R7
endmodule

bind energy_debounce edb_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .energySync (energySync),
  .state      (curState),
  .energyOut  (energyOut),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regRdData  (regRdData)
);

// File: tb/test_energy_debounce.sv
`timescale 1ns/1ps
module test_energy_debounce;
  localparam int PRE_A = 2;
  localparam int PRE_B = 2;
  localparam int SCALE_Q = 1 << PRE_A;
  localparam int SCALE_L = 1 << (PRE_A + PRE_B);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        energyRaw = 1'b0;
  logic        energyOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  energy_debounce #(.SHORT_PRE_LOG2(PRE_A), .LONG_PRE_LOG2(PRE_B)) i_energy_debounce (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .energyRaw(energyRaw), .energyOut(energyOut));

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] hold;
  } vec_t;

  // {cfg, edges held high}; expectation computed from R4/R9/R10
  localparam vec_t VEC [0:9] = '{
    '{32'h8005_0101, 16'd9},
    '{32'h8005_0101, 16'd8},
    '{32'h8000_0101, 16'd4},
    '{32'h8000_0101, 16'd3},
    '{32'h0002_0101, 16'd12},
    '{32'h0002_0101, 16'd11},
    '{32'h0003_0101, 16'd16},
    '{32'h0003_0101, 16'd15},
    '{32'h80FF_0101, 16'd259},
    '{32'h80FF_0101, 16'd258}
  };

  function automatic int riseAt(logic [31:0] cfg);
    return 4 + int'(cfg[23:16]) * (cfg[31] ? 1 : SCALE_Q);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; energyRaw = 1'b0; regWrEn = 1'b0;
    edges(3);
    rstN = 1'b1;
    edges(1);
  endtask

  task automatic writeCfg(logic [31:0] w);
    regWrEn = 1'b1; regWrData = w;
    edges(1);
    regWrEn = 1'b0;
  endtask

  // drive high from quiet and wait until active
  task automatic goActive(logic [31:0] cfg);
    energyRaw = 1'b1;
    edges(riseAt(cfg) + 2);
  endtask

  initial begin
    doReset();
    // R1 reset state
    check("R1 reset word", regRdData, 32'h0010_2040);
    check("R1 reset out", {31'b0, energyOut}, 32'd0);

    // R2 layout and reserved bits
    writeCfg(32'hFFFF_FFFF);
    check("R2 reserved dropped", regRdData, 32'h80FF_FFFF);
    writeCfg(32'h7F12_3456);
    check("R2 field readback", regRdData, 32'h0012_3456);

    // R3 quiet stays quiet
    edges(20);
    check("R3 quiet out", {31'b0, energyOut}, 32'd0);

    // table walk: R4, R9, R10
    foreach (VEC[i]) begin
      doReset();
      writeCfg(VEC[i].cfg);
      energyRaw = 1'b1;
      edges(int'(VEC[i].hold));
      check(VEC[i].cfg[31] ? "R10 R4 rise fast" : "R4 rise scaled",
            {31'b0, energyOut}, {31'b0, (int'(VEC[i].hold) >= riseAt(VEC[i].cfg))});
      if (VEC[i].cfg[23:16] == 8'd0)
        check("R9 zero qualify", {31'b0, energyOut}, {31'b0, (int'(VEC[i].hold) >= 4)});
    end

    // R1 default fields drive the timing: rise at 4 + 16*SCALE_Q
    doReset();
    energyRaw = 1'b1;
    edges(3 + 16 * SCALE_Q);
    check("R1 default qualify early", {31'b0, energyOut}, 32'd0);
    edges(1);
    check("R1 default qualify due", {31'b0, energyOut}, 32'd1);

    // R6 scaled drop-out: longer = 2 -> fall at 4 + 2*SCALE_L
    doReset();
    writeCfg(32'h0001_0102);
    goActive(32'h0001_0102);
    energyRaw = 1'b0;
    edges(3 + 2 * SCALE_L);
    check("R6 scaled drop early", {31'b0, energyOut}, 32'd1);
    edges(1);
    check("R6 scaled drop due", {31'b0, energyOut}, 32'd0);

    // R6 fast drop-out, longer = 3 -> fall at 7
    doReset();
    writeCfg(32'h8000_0103);
    goActive(32'h8000_0103);
    energyRaw = 1'b0;
    edges(6);
    check("R6 fast drop early", {31'b0, energyOut}, 32'd1);
    edges(1);
    check("R6 fast drop due", {31'b0, energyOut}, 32'd0);

    // R9 zero drop-out -> fall at 4
    doReset();
    writeCfg(32'h8000_0100);
    goActive(32'h8000_0100);
    energyRaw = 1'b0;
    edges(3);
    check("R9 zero drop early", {31'b0, energyOut}, 32'd1);
    edges(1);
    check("R9 zero drop due", {31'b0, energyOut}, 32'd0);

    // R7 energy returns during drop-out
    doReset();
    writeCfg(32'h8000_0105);
    goActive(32'h8000_0105);
    energyRaw = 1'b0;
    edges(3);
    energyRaw = 1'b1;
    for (int k = 0; k < 12; k++) begin
      edges(1);
      check("R7 held high on return", {31'b0, energyOut}, 32'd1);
    end
    energyRaw = 1'b0;
    edges(8);
    check("R7 full drop after return early", {31'b0, energyOut}, 32'd1);
    edges(1);
    check("R7 full drop after return due", {31'b0, energyOut}, 32'd0);

    // R5 abandon qualification: energy brief, then absent
    doReset();
    writeCfg(32'h800A_0300);
    energyRaw = 1'b1;
    edges(4);
    energyRaw = 1'b0;
    for (int k = 0; k < 20; k++) begin
      edges(1);
      check("R5 no rise on abort", {31'b0, energyOut}, 32'd0);
    end

    // R8 bounce during qualification restarts the count
    doReset();
    writeCfg(32'h800A_0500);
    energyRaw = 1'b1;
    edges(6);
    energyRaw = 1'b0;
    edges(2);
    energyRaw = 1'b1;
    edges(13);
    check("R8 restart early", {31'b0, energyOut}, 32'd0);
    edges(1);
    check("R8 restart due", {31'b0, energyOut}, 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule